// File: doc/BRIEF.md
# Byte-Lane Data Steering Unit

This block connects a 32-bit internal operand register to a 32-bit external data bus whose lanes are numbered big-endian: operand byte 0, the most significant byte, travels on data bits 31..24, and byte 3 travels on bits 7..0. A 2-bit size code and the two low address bits together fix the routing.

On a write, the unit places the operand bytes on the lanes the address selects and raises only the byte enables of those lanes. On a read, it takes the selected lanes, shifts them down into the low end of the result, and fills the upper bits with zeros. A byte-wide or word-wide port that returns an interrupt vector on the low 8 or 16 data bits is therefore read with no extra logic.

The unit does not size the bus dynamically. The addressed device must accept the full requested width, and no port-size feedback exists. A misaligned word or long-word request is refused with a flag and no bus cycle. A line request runs as four long-word accesses. Address bits 3..2 step modulo 4 from their start value, and bits 1..0 repeat on every beat.

Top module: `lane_router`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `bus_req`, `done`, `rd_valid` and `misalign` are 0.
- R2: Size code 00 is a long word. On a long write, `bus_wdata` equals the operand unchanged, with byte 0 on bits 31..24, and `bus_be` is 4'b1111. On a long read, `rd_data` equals `bus_rdata`.
- R3: Size code 01 is a byte. On a byte write, operand bits 7..0 are copied onto all four lanes, and exactly one enable is high: `bus_be[3-offset]`. Offset 0 is lane bits 31..24, which is `bus_be[3]`.
- R4: Size code 10 is a word. On a word write, operand bits 15..0 appear on both halves of `bus_wdata`. `bus_be` is 4'b1100 for offset 0 and 4'b0011 for offset 2.
- R5: On a byte read, `rd_data` is the lane at bits (31-8*offset)..(24-8*offset), zero-extended. Offset 3 returns bits 7..0, which is where a byte port places an interrupt vector.
- R6: On a word read, `rd_data` is `bus_rdata[31:16]` for offset 0 and `bus_rdata[15:0]` for offset 2, zero-extended.
- R7: The following requests are refused: a word with an odd offset, or a long word with a nonzero offset. For one cycle after acceptance, `misalign` is 1. No bus cycle starts, and `req_ready` stays 1.
- R8: In the cycle after an accepted single access, `bus_req` is 1. `bus_addr` equals the request address (long-word base on bits 31..2, offset on bits 1..0), and `bus_size` equals the request's size code.
- R9: Size code 11 is a line. It runs four accesses with all enables high. On each acknowledged beat, `bus_addr[3:2]` advances by 1 modulo 4, while `bus_addr[1:0]` and bits 31..4 keep their start values. `bus_req` stays 1 until the fourth acknowledge.
- R10: `done` pulses for one cycle after the final acknowledge of an access, and `bus_req` drops in the same cycle. After every read acknowledge, `rd_valid` pulses for one cycle and `rd_data` holds the gathered data.
- R11: While `bus_req` is 1 and `bus_ack` is 0, `bus_addr`, `bus_size`, `bus_be` and `bus_wr` hold their values.
- R12: While a bus cycle is in progress, `req_ready` is 0 and a new `req_valid` is ignored: the bus outputs are unchanged and no further cycle follows.
- R13: During a line write, the data for the next beat is taken from `req_wdata` at each acknowledge that is not the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 long, 01 byte, 10 word, 11 line |
| req_addr | input | 32 | Byte address of the first byte |
| req_wdata | input | 32 | Right-justified write operand |
| req_ready | output | 1 | Idle and able to accept a request |
| misalign | output | 1 | One-cycle pulse when a request is refused |
| done | output | 1 | One-cycle pulse after the last acknowledge |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_data | output | 32 | Right-justified, zero-padded read operand |
| bus_req | output | 1 | Bus access in progress |
| bus_wr | output | 1 | Bus access is a write |
| bus_size | output | 2 | Size code held for the whole access |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Lane enables, bit 3 = data bits 31..24 |
| bus_wdata | output | 32 | Steered write data |
| bus_ack | input | 1 | Acknowledge of the current beat |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
The assertions assume that `bus_ack` is raised only while `bus_req` is high and is low during reset. They also assume that the checked size code never changes without a new accepted request. The bench follows both rules: it pulses `bus_ack` for one cycle only after it has seen `bus_req` high, and it keeps `bus_ack` at 0 through reset. It drives every request in the idle state, except in the one directed test that offers a request during a cycle on purpose to check that it is ignored.

// File: rtl/lane_router_pkg.sv
package lane_router_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int OFF_W      = $clog2(LANES);
    localparam int LINE_BEATS = 4;
    localparam int BEAT_W     = $clog2(LINE_BEATS);

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xsize_e;

    typedef struct packed {
        logic              write;
        xsize_e            size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // Word needs an even offset, long word needs offset zero.
    function automatic logic is_misaligned(xsize_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_WORD: return off[0];
            SZ_LONG: return off != '0;
            default: return 1'b0;
        endcase
    endfunction

    // Big-endian: offset 0 maps to the top lane.
    function automatic logic [OFF_W-1:0] lane_for(logic [OFF_W-1:0] off);
        return OFF_W'(LANES - 1) - off;
    endfunction

endpackage

// File: rtl/lane_router_wr.sv
module lane_router_wr
    import lane_router_pkg::*;
(
    input  xsize_e             size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  lane_data,
    output logic [LANES-1:0]   lane_en
);
    localparam int HALF = LANES / 2;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] d;
        logic       e;
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    d = wdata[7:0];
                    e = (lane_for(off) == OFF_W'(l));
                end
                SZ_WORD: begin
                    d = wdata[8*(l%HALF) +: 8];
                    e = (off[OFF_W-1] == (l < HALF));
                end
                default: begin
                    d = wdata[8*l +: 8];
                    e = 1'b1;
                end
            endcase
        end
        assign lane_data[8*l +: 8] = d;
        assign lane_en[l]          = e;
    end

endmodule

// File: rtl/lane_router_rd.sv
module lane_router_rd
    import lane_router_pkg::*;
(
    input  xsize_e             size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0]  operand
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        case (size)
            SZ_BYTE: operand = DATA_W'(bus_rdata[8*lane_for(off) +: 8]);
            SZ_WORD: operand = off[OFF_W-1] ? DATA_W'(bus_rdata[HALF_W-1:0])
                                            : DATA_W'(bus_rdata[DATA_W-1:HALF_W]);
            default: operand = bus_rdata;
        endcase
    end

endmodule

// File: rtl/lane_router_seq.sv
module lane_router_seq #(
    parameter int BEATS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      start_line,
    input  logic                      ack,
    output logic                      busy,
    output logic [$clog2(BEATS)-1:0]  beat,
    output logic                      last,
    output logic                      done
);
    localparam int CNT_W = $clog2(BEATS);

    logic line_q;

    assign last = !line_q || (beat == CNT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            beat   <= '0;
            line_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                beat   <= '0;
                line_q <= start_line;
            end else if (busy && ack) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lane_router.sv
module lane_router
    import lane_router_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                misalign,
    output logic                done,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                bus_req,
    output logic                bus_wr,
    output logic [1:0]          bus_size,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [LANES-1:0]    bus_be,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_ack,
    input  logic [DATA_W-1:0]   bus_rdata
);
    localparam int IDX_LO = OFF_W;
    localparam int IDX_HI = OFF_W + BEAT_W - 1;

    xsize_e            in_size;
    xfer_t             op_q;
    logic              busy, last, seq_done;
    logic [BEAT_W-1:0] beat;
    logic              accept, bad, start, beat_ack;
    logic [DATA_W-1:0] gathered;

    assign in_size  = xsize_e'(req_size);
    assign accept   = req_valid && !busy;
    assign bad      = is_misaligned(in_size, req_addr[OFF_W-1:0]);
    assign start    = accept && !bad;
    assign beat_ack = busy && bus_ack;

    lane_router_seq #(.BEATS(LINE_BEATS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line (in_size == SZ_LINE),
        .ack        (bus_ack),
        .busy       (busy),
        .beat       (beat),
        .last       (last),
        .done       (seq_done)
    );

    lane_router_wr u_wr (
        .size      (op_q.size),
        .off       (op_q.addr[OFF_W-1:0]),
        .wdata     (op_q.wdata),
        .lane_data (bus_wdata),
        .lane_en   (bus_be)
    );

    lane_router_rd u_rd (
        .size      (op_q.size),
        .off       (op_q.addr[OFF_W-1:0]),
        .bus_rdata (bus_rdata),
        .operand   (gathered)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= '0;
            misalign <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            misalign <= accept && bad;
            rd_valid <= beat_ack && !op_q.write;
            if (start) begin
                op_q <= '{write: req_write, size: in_size,
                          addr: req_addr, wdata: req_wdata};
            end else if (beat_ack && !last && op_q.write) begin
                op_q.wdata <= req_wdata;
            end
            if (beat_ack && !op_q.write) begin
                rd_data <= gathered;
            end
        end
    end

    // Line beats step bits 3..2; the offset bits repeat unchanged.
    always_comb begin
        bus_addr = op_q.addr;
        if (op_q.size == SZ_LINE) begin
            bus_addr[IDX_HI:IDX_LO] = op_q.addr[IDX_HI:IDX_LO] + beat;
        end
    end

    assign bus_req   = busy;
    assign bus_wr    = busy && op_q.write;
    assign bus_size  = op_q.size;
    assign req_ready = !busy;
    assign done      = seq_done;

endmodule

// File: rtl/lane_router_chk.sv
module lane_router_chk
    import lane_router_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_ack,
    input logic               bus_wr,
    input logic [1:0]         bus_size,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [LANES-1:0]   bus_be,
    input logic               misalign,
    input logic               done,
    input logic               rd_valid
);
    localparam int LO = OFF_W;
    localparam int HI = OFF_W + BEAT_W - 1;

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_size == 2'b01 |-> $countones(bus_be) == 1);

    p_word_half_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_size == 2'b10 |-> (bus_be == 4'b1100 || bus_be == 4'b0011));

    p_full_lanes_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req && (bus_size == 2'b00 || bus_size == 2'b11) |-> bus_be == '1);

    p_line_step_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack && bus_size == 2'b11 |=>
            !bus_req ||
            (bus_addr[HI:LO] == BEAT_W'($past(bus_addr[HI:LO]) + 1'b1) &&
             bus_addr[OFF_W-1:0] == $past(bus_addr[OFF_W-1:0])));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size)
                                && $stable(bus_be) && $stable(bus_wr));

    p_single_ends_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack && bus_size != 2'b11 |=> !bus_req && done);

    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_ack) && !bus_req);

    p_rdv_after_ack_r10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_req && bus_ack && !bus_wr));

    p_refused_no_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        misalign |-> !bus_req);

endmodule

bind lane_router lane_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .misalign (misalign),
    .done     (done),
    .rd_valid (rd_valid)
);

// File: tb/lane_router_bench.sv
`timescale 1ns/1ps
module lane_router_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, misalign, done, rd_valid;
    logic [31:0] rd_data;
    logic        bus_req, bus_wr;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lane_router u_lane_router (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rbus;
        logic [3:0]  be;
        logic [31:0] exp;
        logic        mis;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 1'b1, 2'b00, 32'h0000_1000, 32'h1122_3344, 32'h0, 4'b1111, 32'h1122_3344, 1'b0}, // R2
        '{8'd3, 1'b1, 2'b01, 32'h0000_1001, 32'h0000_00AB, 32'h0, 4'b0100, 32'hABAB_ABAB, 1'b0}, // R3
        '{8'd3, 1'b1, 2'b01, 32'h0000_1003, 32'h0000_005A, 32'h0, 4'b0001, 32'h5A5A_5A5A, 1'b0}, // R3
        '{8'd3, 1'b1, 2'b01, 32'h0000_2000, 32'hFFFF_FF77, 32'h0, 4'b1000, 32'h7777_7777, 1'b0}, // R3
        '{8'd4, 1'b1, 2'b10, 32'h0000_3000, 32'h0000_BEEF, 32'h0, 4'b1100, 32'hBEEF_BEEF, 1'b0}, // R4
        '{8'd4, 1'b1, 2'b10, 32'h0000_3002, 32'h1234_5678, 32'h0, 4'b0011, 32'h5678_5678, 1'b0}, // R4
        '{8'd5, 1'b0, 2'b01, 32'h0000_4000, 32'h0, 32'hA1B2_C3D4, 4'b1000, 32'h0000_00A1, 1'b0}, // R5
        '{8'd5, 1'b0, 2'b01, 32'h0000_4002, 32'h0, 32'hA1B2_C3D4, 4'b0010, 32'h0000_00C3, 1'b0}, // R5
        '{8'd5, 1'b0, 2'b01, 32'h0000_4003, 32'h0, 32'hDEAD_BE40, 4'b0001, 32'h0000_0040, 1'b0}, // R5 vector
        '{8'd6, 1'b0, 2'b10, 32'h0000_4800, 32'h0, 32'hCAFE_F00D, 4'b1100, 32'h0000_CAFE, 1'b0}, // R6
        '{8'd6, 1'b0, 2'b10, 32'h0000_4802, 32'h0, 32'hCAFE_F00D, 4'b0011, 32'h0000_F00D, 1'b0}, // R6
        '{8'd2, 1'b0, 2'b00, 32'h0000_5000, 32'h0, 32'h89AB_CDEF, 4'b1111, 32'h89AB_CDEF, 1'b0}, // R2
        '{8'd7, 1'b1, 2'b10, 32'h0000_6001, 32'h0000_1111, 32'h0, 4'b0000, 32'h0, 1'b1},         // R7
        '{8'd7, 1'b0, 2'b00, 32'h0000_6002, 32'h0, 32'h0, 4'b0000, 32'h0, 1'b1},                 // R7
        '{8'd7, 1'b0, 2'b10, 32'h0000_6003, 32'h0, 32'h0, 4'b0000, 32'h0, 1'b1}                  // R7
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack_beat(input logic [31:0] rb);
        bus_ack = 1'b1; bus_rdata = rb;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    function automatic logic [31:0] line_addr(input logic [31:0] a, input int k);
        return {a[31:4], 2'(a[3:2] + 2'(k)), a[1:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        string t;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk({bus_req, done, rd_valid, misalign} == 4'b0, "R1 outputs",
            32'({bus_req, done, rd_valid, misalign}), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            t = $sformatf("R%0d vec%0d", VEC[i].req, i);
            issue(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd);
            if (VEC[i].mis) begin
                chk(misalign == 1'b1 && bus_req == 1'b0 && req_ready == 1'b1,
                    {t, " misalign"}, {misalign, bus_req, req_ready}, 32'b101);
                @(negedge clk);
                chk(misalign == 1'b0 && bus_req == 1'b0, {t, " R7 no cycle"},
                    {misalign, bus_req}, 32'b00);
            end else begin
                chk(bus_req == 1'b1 && bus_addr == VEC[i].addr, {t, " R8 addr"},
                    bus_addr, VEC[i].addr);
                chk(bus_size == VEC[i].sz && bus_wr == VEC[i].wr, {t, " R8 size"},
                    {bus_wr, bus_size}, {VEC[i].wr, VEC[i].sz});
                chk(bus_be == VEC[i].be, {t, " be"}, 32'(bus_be), 32'(VEC[i].be));
                if (VEC[i].wr)
                    chk(bus_wdata == VEC[i].exp, {t, " wdata"}, bus_wdata, VEC[i].exp);
                ack_beat(VEC[i].rbus);
                chk(done == 1'b1 && bus_req == 1'b0, {t, " R10 done"},
                    {done, bus_req}, 32'b10);
                if (!VEC[i].wr)
                    chk(rd_valid == 1'b1 && rd_data == VEC[i].exp, {t, " rdata"},
                        rd_data, VEC[i].exp);
                @(negedge clk);
                chk(done == 1'b0 && rd_valid == 1'b0, {t, " R10 pulse"},
                    {done, rd_valid}, 32'b0);
            end
        end

        // R9 line read starting at bits3:2=2, offset 2
        issue(1'b0, 2'b11, 32'h0000_800A, 32'h0);
        for (int k = 0; k < 4; k++) begin
            chk(bus_req == 1'b1 && bus_addr == line_addr(32'h0000_800A, k),
                $sformatf("R9 line rd beat%0d addr", k), bus_addr, line_addr(32'h0000_800A, k));
            chk(bus_be == 4'hF && bus_size == 2'b11, $sformatf("R9 line beat%0d be", k),
                {bus_size, bus_be}, {2'b11, 4'hF});
            ack_beat(32'h1000_0000 + 32'(k));
            chk(rd_valid == 1'b1 && rd_data == 32'h1000_0000 + 32'(k),
                $sformatf("R10 line rd beat%0d data", k), rd_data, 32'h1000_0000 + 32'(k));
            chk(done == (k == 3) && bus_req == (k != 3), $sformatf("R9 line beat%0d req", k),
                {done, bus_req}, {(k == 3), (k != 3)});
        end
        @(negedge clk);

        // R13 line write, new data per beat
        issue(1'b1, 2'b11, 32'h0000_9004, 32'hD000_0000);
        for (int k = 0; k < 4; k++) begin
            chk(bus_wdata == 32'hD000_0000 + 32'(k) && bus_addr == line_addr(32'h0000_9004, k),
                $sformatf("R13 line wr beat%0d", k), bus_wdata, 32'hD000_0000 + 32'(k));
            req_wdata = 32'hD000_0000 + 32'(k + 1);
            ack_beat(32'h0);
        end
        chk(done == 1'b1 && bus_req == 1'b0, "R10 line wr done", {done, bus_req}, 32'b10);
        @(negedge clk);

        // R11 stall and R12 request while busy
        issue(1'b0, 2'b00, 32'h0000_A000, 32'h0);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b01; req_addr = 32'h0000_B003;
        chk(req_ready == 1'b0, "R12 not ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(bus_req == 1'b1 && bus_addr == 32'h0000_A000 && bus_size == 2'b00 && bus_wr == 1'b0,
            "R11 R12 held", bus_addr, 32'h0000_A000);
        ack_beat(32'h5555_AAAA);
        chk(done == 1'b1 && rd_data == 32'h5555_AAAA, "R12 original read", rd_data, 32'h5555_AAAA);
        @(negedge clk);
        chk(bus_req == 1'b0 && misalign == 1'b0, "R12 no extra cycle", {bus_req, misalign}, 32'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule